// File: doc/BRIEF.md
# Memory Fault Status Capture Registers

This block keeps a record of the first data-side translation fault so that a trap handler can inspect it. When a fault is signalled, three registers are loaded in the next cycle. The first holds the faulting virtual address. The second is a status word that combines the fault flags with the opcode and destination-register fields of the instruction that faulted. The third is a formatted pointer into the page table, made from the page-table base and the virtual page number of the faulting address.

After a capture the registers are locked. Later faults leave them unchanged until software reads the address register, and that read opens the lock again. A fault raised on a speculative (wrong-path) access is never recorded. Such a fault also does not set the lock.

Top module: `mfsc_capture`

## Requirements
- R1: While `rst` is high, all three registers are cleared and the lock opens, so the first non-speculative fault after reset is captured.
- R2: A fault strobe with `flt_spec_i` low while the lock is open loads `fva_o` with `flt_va_i` on the next clock edge.
- R3: The captured status word holds the opcode at bits 16:11, the destination-register field at bits 10:6 and the fault flags at bits 5:0.
- R4: The captured formatted address equals `ptbase_i` ORed with the virtual page number `flt_va_i[VA_W-1:PG_OFS]`, zero-extended and shifted left by 3.
- R5: Once a capture has happened, further faults do not change any of the three registers while no address-register read occurs.
- R6: A pulse on `va_rd_i` opens the lock without changing the registers, so the next non-speculative fault is captured.
- R7: A fault with `flt_spec_i` high changes no register and does not set the lock.
- R8: A fault and an address-register read in the same cycle capture the new fault, and the lock stays set afterwards.
- R9: A read of the address register while the lock is open leaves all registers unchanged.
- R10: The fault flags are stored unchanged. Their bits are: 0 write, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 TLB miss, 5 bad virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_vld_i | input | 1 | Fault strobe, one cycle per fault |
| flt_spec_i | input | 1 | Fault belongs to a speculative access |
| flt_va_i | input | VA_W | Faulting virtual address |
| flt_flags_i | input | 6 | Fault flags (see R10) |
| flt_opc_i | input | 6 | Opcode of the faulting instruction |
| flt_rfld_i | input | 5 | Destination-register field of the faulting instruction |
| ptbase_i | input | PTB_W | Page-table base register |
| va_rd_i | input | 1 | Read strobe of the faulting-address register |
| fva_o | output | VA_W | Captured faulting address |
| fstat_o | output | 17 | Captured status word |
| fform_o | output | PTB_W | Captured formatted page-table pointer |

## Verification
The lock state has no port of its own, so the bench can only detect it from whether a later fault is recorded. The hardest case to reach is a read and a fault landing in the same cycle while the lock is held. To get there, the stimulus first captures one fault, then raises the read and a second fault together on one edge. It follows with a third fault to show that the lock stayed set. A speculative fault combined with a read is used to show that the read alone opens the lock.

// File: rtl/mfsc_pkg.sv
package mfsc_pkg;

    localparam int OPC_W  = 6;
    localparam int RFLD_W = 5;
    localparam int FLG_W  = 6;
    localparam int STAT_W = OPC_W + RFLD_W + FLG_W;

    // flag bit 0 is the least significant member
    typedef struct packed {
        logic bad_va;
        logic tlb_miss;
        logic fonw;
        logic fonr;
        logic acv;
        logic wr;
    } flt_flags_t;

    // packed msb first: opcode 16:11, register field 10:6, flags 5:0
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RFLD_W-1:0] rfld;
        flt_flags_t        flags;
    } stat_word_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_st_e;

    function automatic stat_word_t pack_status(
        input logic [OPC_W-1:0]  opc,
        input logic [RFLD_W-1:0] rfld,
        input logic [FLG_W-1:0]  flags
    );
        stat_word_t s;
        s.opc   = opc;
        s.rfld  = rfld;
        s.flags = flt_flags_t'(flags);
        return s;
    endfunction

endpackage

// File: rtl/mfsc_lock_ctrl.sv
module mfsc_lock_ctrl
    import mfsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault_i,
    input  logic spec_i,
    input  logic rd_i,
    output logic cap_en_o,
    output logic held_o
);
    lock_st_e st_q, st_d;

    // a read in the same cycle opens the lock before the fault is judged
    assign cap_en_o = fault_i && !spec_i && ((st_q == LK_OPEN) || rd_i);
    assign held_o   = (st_q == LK_HELD);

    always_comb begin
        st_d = st_q;
        if (cap_en_o)  st_d = LK_HELD;
        else if (rd_i) st_d = LK_OPEN;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_OPEN;
        else     st_q <= st_d;
    end

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !fault_i) |=> !held_o);

    // R7
    spec_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        (!held_o && spec_i) |=> !held_o);

    // R1
    reset_open_chk: assert property (@(posedge clk)
        rst |=> !held_o);

endmodule

// File: rtl/mfsc_va_format.sv
module mfsc_va_format #(
    parameter int VA_W   = 43,
    parameter int PG_OFS = 13,
    parameter int PTB_W  = 64
) (
    input  logic [VA_W-1:0]  va_i,
    input  logic [PTB_W-1:0] ptbase_i,
    output logic [PTB_W-1:0] form_o
);
    localparam int VPN_W = VA_W - PG_OFS;
    localparam int PAD_W = PTB_W - VPN_W;

    logic [PTB_W-1:0] vpn_ext;

    assign vpn_ext = {{PAD_W{1'b0}}, va_i[VA_W-1:PG_OFS]};
    assign form_o  = ptbase_i | (vpn_ext << 3);

    initial begin
        if (PTB_W < VPN_W + 3)
            $error("mfsc_va_format: PTB_W too narrow for shifted page number");
    end
endmodule

// File: rtl/mfsc_hold_reg.sv
module mfsc_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (en_i) q_o <= d_i;
    end
endmodule

// File: rtl/mfsc_capture.sv
module mfsc_capture
    import mfsc_pkg::*;
#(
    parameter int VA_W   = 43,
    parameter int PG_OFS = 13,
    parameter int PTB_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_vld_i,
    input  logic              flt_spec_i,
    input  logic [VA_W-1:0]   flt_va_i,
    input  logic [FLG_W-1:0]  flt_flags_i,
    input  logic [OPC_W-1:0]  flt_opc_i,
    input  logic [RFLD_W-1:0] flt_rfld_i,
    input  logic [PTB_W-1:0]  ptbase_i,
    input  logic              va_rd_i,
    output logic [VA_W-1:0]   fva_o,
    output logic [STAT_W-1:0] fstat_o,
    output logic [PTB_W-1:0]  fform_o
);
    logic             cap_en;
    logic             held;
    stat_word_t       stat_d;
    logic [PTB_W-1:0] form_d;

    mfsc_lock_ctrl u_lock (
        .clk      (clk),
        .rst      (rst),
        .fault_i  (flt_vld_i),
        .spec_i   (flt_spec_i),
        .rd_i     (va_rd_i),
        .cap_en_o (cap_en),
        .held_o   (held)
    );

    assign stat_d = pack_status(flt_opc_i, flt_rfld_i, flt_flags_i);

    mfsc_va_format #(.VA_W(VA_W), .PG_OFS(PG_OFS), .PTB_W(PTB_W)) u_fmt (
        .va_i     (flt_va_i),
        .ptbase_i (ptbase_i),
        .form_o   (form_d)
    );

    mfsc_hold_reg #(.W(VA_W)) u_va_reg (
        .clk (clk), .rst (rst), .en_i (cap_en), .d_i (flt_va_i), .q_o (fva_o)
    );

    mfsc_hold_reg #(.W(STAT_W)) u_stat_reg (
        .clk (clk), .rst (rst), .en_i (cap_en), .d_i (stat_d), .q_o (fstat_o)
    );

    mfsc_hold_reg #(.W(PTB_W)) u_form_reg (
        .clk (clk), .rst (rst), .en_i (cap_en), .d_i (form_d), .q_o (fform_o)
    );

    // R2
    capture_va_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_vld_i && !flt_spec_i && !held) |=> (fva_o == $past(flt_va_i)));

    // R3
    status_pack_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_vld_i && !flt_spec_i && !held) |=>
        (fstat_o[16:11] == $past(flt_opc_i) && fstat_o[10:6] == $past(flt_rfld_i)
         && fstat_o[5:0] == $past(flt_flags_i)));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !va_rd_i) |=> ($stable(fva_o) && $stable(fstat_o) && $stable(fform_o)));

    // R7
    spec_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_spec_i || !flt_vld_i) |=> ($stable(fva_o) && $stable(fstat_o) && $stable(fform_o)));

    // R8
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_vld_i && !flt_spec_i && va_rd_i) |=> (held && fva_o == $past(flt_va_i)));

endmodule

// File: tb/mfsc_capture_tb.sv
`timescale 1ns/1ps
module mfsc_capture_tb;
    localparam int VA_W   = 43;
    localparam int PG_OFS = 13;
    localparam int PTB_W  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flt_vld_i = 1'b0;
    logic              flt_spec_i = 1'b0;
    logic [VA_W-1:0]   flt_va_i = '0;
    logic [5:0]        flt_flags_i = '0;
    logic [5:0]        flt_opc_i = '0;
    logic [4:0]        flt_rfld_i = '0;
    logic [PTB_W-1:0]  ptbase_i = '0;
    logic              va_rd_i = 1'b0;
    logic [VA_W-1:0]   fva_o;
    logic [16:0]       fstat_o;
    logic [PTB_W-1:0]  fform_o;

    always #2.5 clk = ~clk;

    mfsc_capture #(.VA_W(VA_W), .PG_OFS(PG_OFS), .PTB_W(PTB_W)) u_dut (
        .clk (clk), .rst (rst), .flt_vld_i (flt_vld_i), .flt_spec_i (flt_spec_i),
        .flt_va_i (flt_va_i), .flt_flags_i (flt_flags_i), .flt_opc_i (flt_opc_i),
        .flt_rfld_i (flt_rfld_i), .ptbase_i (ptbase_i), .va_rd_i (va_rd_i),
        .fva_o (fva_o), .fstat_o (fstat_o), .fform_o (fform_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit               m_lock;
    logic [VA_W-1:0]  m_va;
    logic [16:0]      m_st;
    logic [PTB_W-1:0] m_ff;

    task automatic model_edge();
        logic [PTB_W-1:0] vpn;
        if (rst) begin
            m_lock = 0; m_va = '0; m_st = '0; m_ff = '0;
        end else if (flt_vld_i && !flt_spec_i && (!m_lock || va_rd_i)) begin
            vpn    = PTB_W'(flt_va_i >> PG_OFS);
            m_va   = flt_va_i;
            m_st   = {flt_opc_i, flt_rfld_i, flt_flags_i};
            m_ff   = ptbase_i | (vpn << 3);
            m_lock = 1;
        end else if (va_rd_i) begin
            m_lock = 0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (fva_o !== m_va) begin
            errors++;
            $display("FAIL %s fva act=%h exp=%h", tag, fva_o, m_va);
        end
        checks++;
        if (fstat_o !== m_st) begin
            errors++;
            $display("FAIL %s fstat act=%h exp=%h", tag, fstat_o, m_st);
        end
        checks++;
        if (fform_o !== m_ff) begin
            errors++;
            $display("FAIL %s fform act=%h exp=%h", tag, fform_o, m_ff);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, compare
    task automatic step(input string tag, input bit fv, input bit sp, input bit rd,
                        input logic [VA_W-1:0] va, input logic [5:0] fl,
                        input logic [5:0] opc, input logic [4:0] rf,
                        input logic [PTB_W-1:0] ptb);
        flt_vld_i = fv; flt_spec_i = sp; va_rd_i = rd; flt_va_i = va;
        flt_flags_i = fl; flt_opc_i = opc; flt_rfld_i = rf; ptbase_i = ptb;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, '0, '0, '0, '0, ptbase_i);
    endtask

    task automatic do_reset();
        rst = 1;
        idle("R1");
        idle("R1");
        rst = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        idle("R1");
        // R9: read with lock open changes nothing
        step("R9", 0, 0, 1, 43'h0, 6'h0, 6'h0, 5'h0, 64'h0);
        // R7: speculative fault is dropped and sets no lock
        step("R7", 1, 1, 0, 43'h7AB_CDEF_1234, 6'h11, 6'h2A, 5'h1F, 64'hFFFF_0000_0000_0000);
        // R2 R3 R4 R10: first real fault captured (flags: wr + tlb miss)
        step("R2", 1, 0, 0, 43'h123_4567_89AB, 6'b010001, 6'h3C, 5'h15, 64'hA000_0000_0000_0000);
        // R5: later faults ignored while locked
        step("R5", 1, 0, 0, 43'h7FF_FFFF_FFFF, 6'h3F, 6'h3F, 5'h1F, 64'h1);
        idle("R5");
        step("R5", 1, 0, 0, 43'h000_0000_2000, 6'h02, 6'h01, 5'h01, 64'h0);
        // R6: read releases, registers unchanged, next fault captured
        step("R6", 0, 0, 1, 43'h0, 6'h0, 6'h0, 5'h0, 64'h0);
        step("R6", 1, 0, 0, 43'h555_5555_5555, 6'b100110, 6'h15, 5'h0A, 64'h0000_0000_0000_0007);
        // R8: read and fault together capture the new fault and stay locked
        step("R8", 1, 0, 1, 43'h2AA_AAAA_AAAA, 6'b001000, 6'h07, 5'h1E, 64'h8000_0000_0000_0000);
        step("R8", 1, 0, 0, 43'h111_1111_1111, 6'h3F, 6'h00, 5'h00, 64'h0);
        // R6 R7: speculative fault plus read opens lock without capture
        step("R7", 1, 1, 1, 43'h333_3333_3333, 6'h3F, 6'h3F, 5'h1F, 64'h0);
        // R10: each flag bit alone (0 wr .. 5 bad va)
        for (int b = 0; b < 6; b++) begin
            step("R10", 1, 0, 1, VA_W'(64'h1000 * (b + 1)), 6'(1 << b), 6'(b), 5'(b), 64'h0);
        end
        // R4: page number at the top of the address range
        step("R4", 1, 0, 1, 43'h400_0000_0000, 6'h20, 6'h3F, 5'h1F, 64'h0000_0001_0000_0000);
        // R1: reset while locked, then first fault captured
        do_reset();
        step("R1", 1, 0, 0, 43'h0AB_CDEF_0123, 6'h04, 6'h12, 5'h09, 64'h0);
        step("R5", 1, 0, 0, 43'h0FF_0000_0000, 6'h01, 6'h01, 5'h01, 64'h0);
        idle("R5");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule